// File: doc/BRIEF.md
# Time-Sliced Shared Memory Controller with Atomic Lock Swap

This block sits between four processor cores and a shared word memory. Access is granted by time division: a slot counter walks the cores in a fixed cyclic order, and each slot has a fixed length. It is one bus transfer cycle followed by the cycles of one memory burst. In its own slot a core's pending request is taken, served inside the memory phase and answered in the slot's final cycle. A core with nothing pending leaves its slot empty, and the schedule never changes shape.

Besides ordinary reads and writes, a core may issue an atomic lock swap. The controller reads the addressed word and writes it back with bit 0 forced to 1, inside the same memory phase. It returns the word as it stood before. Bit 0 is the lock: 0 means free and 1 means held. Because the read and the write both happen inside one slot, the bus is never held across them and no other core waits longer. A lock is released with an ordinary write that clears bit 0.

Each core keeps its request valid, with stable fields, until its response arrives, and has at most one request in flight.

Top module: `tdma_lock_ctrl`

## Requirements
- R1: Slots are served in the fixed order core 0, 1, 2, 3, then back to 0. Each slot lasts BUS_LAT + MEM_LAT cycles (5 by default). A request is answered in the last cycle of its own core's slot.
- R2: A request whose valid is held is answered within NCORE*SLOT_LEN + SLOT_LEN cycles of valid being raised.
- R3: An empty slot is not handed to another core. While only one core has a request, no other core's response valid is raised.
- R4: Operation code 2'b00 (read) returns the stored 32-bit word.
- R5: Operation code 2'b01 (write) stores the write data. Its response returns the word held before the write.
- R6: Operation code 2'b10 (lock swap) returns the word held before and leaves bit 0 of that word at 1. Bits 31:1 are unchanged.
- R7: Lock swaps never lengthen a slot. When all four cores raise a swap on one free lock in the same cycle, exactly one of them sees bit 0 = 0, and the four responses span exactly 3*SLOT_LEN cycles from first to last.
- R8: A write with bit 0 = 0 releases the lock, and the next swap on that word returns bit 0 = 0.
- R9: Each accepted request gets exactly one response valid pulse, one cycle wide. At most one core's response valid is high in any cycle.
- R10: After reset every response valid is low and every memory word reads 0.
- R11: Operation code 2'b11 behaves as a read and leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORE | Per-core request pending, held until the response |
| req_op | input | 2*NCORE | Per-core operation code: 00 read, 01 write, 10 lock swap, 11 read |
| req_addr | input | AW*NCORE | Per-core word address |
| req_wdata | input | DW*NCORE | Per-core write data |
| resp_valid | output | NCORE | Per-core one-cycle response pulse |
| resp_rdata | output | DW*NCORE | Per-core returned word (value before any write in that slot) |

## Verification
The sharpest case is four simultaneous swaps on one free lock. A controller that lost atomicity would hand out the lock twice. One that locked the bus or stretched a slot for a swap would spread the four answers over more than three slot lengths. Alternating acquire, held-retry, release and re-acquire on one word shows whether the write-back keeps bits 31:1 and only sets bit 0. A design that wrote a whole 1 or forgot the write would return the wrong word on the following read. Single-core traffic checks that idle slots stay idle: a design that gave spare slots to whoever was waiting would answer another core or answer out of turn. The reserved code checks that a fourth operation does not write memory.

// File: rtl/tdma_lock_pkg.sv
package tdma_lock_pkg;
    typedef enum logic [1:0] {
        OP_READ     = 2'b00,
        OP_WRITE    = 2'b01,
        OP_SWAP     = 2'b10,
        OP_READ_ALT = 2'b11
    } op_e;
endpackage

// File: rtl/tdma_slot_timer.sv
module tdma_slot_timer #(
    parameter int NCORE    = 4,
    parameter int SLOT_LEN = 5,
    localparam int OW = (NCORE > 1) ? $clog2(NCORE) : 1,
    localparam int PW = $clog2(SLOT_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [OW-1:0] owner,
    output logic [PW-1:0] phase,
    output logic          slot_last
);
    localparam logic [PW-1:0] LAST_PH = PW'(SLOT_LEN - 1);
    localparam logic [OW-1:0] LAST_OW = OW'(NCORE - 1);

    typedef struct packed {
        logic [OW-1:0] owner;
        logic [PW-1:0] phase;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == LAST_PH) begin
            st_d.phase = '0;
            st_d.owner = (st_q.owner == LAST_OW) ? '0 : st_q.owner + 1'b1;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owner     = st_q.owner;
    assign phase     = st_q.phase;
    assign slot_last = (st_q.phase == LAST_PH);

    // Rotation advances by exactly one core at each slot boundary (R1)
    p_rotate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_last |=> (owner == (($past(owner) == LAST_OW) ? '0 : $past(owner) + 1'b1)));
    // Owner never changes inside a slot, so no slot is stretched or cut (R7)
    p_slot_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_last |=> ($stable(owner) && phase == $past(phase) + 1'b1));
endmodule

// File: rtl/lock_word_mem.sv
module lock_word_mem #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] store_q [DEPTH];
    logic [DW-1:0] rd_data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
            rd_data_q <= '0;
        end else begin
            if (rd_en) rd_data_q <= store_q[rd_addr];
            if (wr_en) store_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = rd_data_q;

    // A written word holds the written value on the next cycle (R5)
    p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (store_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/tdma_lock_ctrl.sv
module tdma_lock_ctrl
    import tdma_lock_pkg::*;
#(
    parameter int NCORE   = 4,
    parameter int BUS_LAT = 1,
    parameter int MEM_LAT = 4,
    parameter int DEPTH   = 32,
    parameter int DW      = 32,
    localparam int AW       = $clog2(DEPTH),
    localparam int SLOT_LEN = BUS_LAT + MEM_LAT,
    localparam int OW       = (NCORE > 1) ? $clog2(NCORE) : 1,
    localparam int PW       = $clog2(SLOT_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCORE-1:0]    req_valid,
    input  logic [2*NCORE-1:0]  req_op,
    input  logic [AW*NCORE-1:0] req_addr,
    input  logic [DW*NCORE-1:0] req_wdata,
    output logic [NCORE-1:0]    resp_valid,
    output logic [DW*NCORE-1:0] resp_rdata
);
    // Phase where the request is taken, the word is read, written back
    localparam logic [PW-1:0] PH_TAKE  = PW'(BUS_LAT - 1);
    localparam logic [PW-1:0] PH_READ  = PW'(BUS_LAT);
    localparam logic [PW-1:0] PH_WRITE = PW'(BUS_LAT + 1);
    localparam logic [PW-1:0] PH_LAST  = PW'(SLOT_LEN - 1);

    typedef struct packed {
        logic          active;
        logic [OW-1:0] core;
        op_e           op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } xfer_t;

    xfer_t st_d, st_q;

    logic [OW-1:0] owner;
    logic [PW-1:0] phase;
    logic          slot_last;
    logic          rd_en, wr_en;
    logic [DW-1:0] rd_data, wr_data;

    tdma_slot_timer #(.NCORE(NCORE), .SLOT_LEN(SLOT_LEN)) i_timer (
        .clk(clk), .rst_n(rst_n),
        .owner(owner), .phase(phase), .slot_last(slot_last)
    );

    lock_word_mem #(.DEPTH(DEPTH), .DW(DW)) i_mem (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(st_q.addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(st_q.addr), .wr_data(wr_data)
    );

    always_comb begin
        st_d = st_q;
        if (phase == PH_TAKE) begin
            st_d.active = req_valid[owner];
            st_d.core   = owner;
            st_d.op     = op_e'(req_op[owner*2 +: 2]);
            st_d.addr   = req_addr[owner*AW +: AW];
            st_d.wdata  = req_wdata[owner*DW +: DW];
        end else if (slot_last) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Memory phase: read first, then write back in the same slot
    always_comb begin
        rd_en   = st_q.active && (phase == PH_READ);
        wr_en   = 1'b0;
        wr_data = st_q.wdata;
        if (st_q.active && phase == PH_WRITE) begin
            if (st_q.op == OP_WRITE) begin
                wr_en = 1'b1;
            end else if (st_q.op == OP_SWAP) begin
                wr_en   = 1'b1;
                wr_data = {rd_data[DW-1:1], 1'b1};
            end
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_resp
        assign resp_valid[c] = st_q.active && (phase == PH_LAST) && (st_q.core == OW'(c));
        assign resp_rdata[c*DW +: DW] = resp_valid[c] ? rd_data : '0;
    end

    // Never two responses at once (R9)
    p_onehot_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resp_valid));
    // A response pulse lasts one cycle (R9)
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid != '0) |=> (resp_valid == '0));
    // Only the slot owner is ever answered (R3)
    p_owner_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid != '0) |-> resp_valid[owner]);
    // Memory is only touched in the memory phase of an occupied slot (R7)
    p_mem_in_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |-> (phase != PH_TAKE && phase != PH_LAST));
endmodule

// File: tb/test_tdma_lock_ctrl.sv
module test_tdma_lock_ctrl;
    localparam int NCORE = 4;
    localparam int AW    = 5;
    localparam int DW    = 32;
    localparam int SLOT  = 5;
    localparam int NV    = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCORE-1:0]    req_valid = '0;
    logic [2*NCORE-1:0]  req_op = '0;
    logic [AW*NCORE-1:0] req_addr = '0;
    logic [DW*NCORE-1:0] req_wdata = '0;
    logic [NCORE-1:0]    resp_valid;
    logic [DW*NCORE-1:0] resp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tdma_lock_ctrl #(.NCORE(NCORE), .BUS_LAT(1), .MEM_LAT(4), .DEPTH(32), .DW(DW)) i_tdma_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata)
    );

    // Vector table: core, op, addr, wdata, expected returned word
    localparam int          V_CORE [NV] = '{0, 1, 2, 3, 0, 1, 2, 3, 0, 1, 2, 3};
    localparam logic [1:0]  V_OP   [NV] = '{2'b01, 2'b00, 2'b10, 2'b00, 2'b10, 2'b01,
                                           2'b10, 2'b01, 2'b00, 2'b10, 2'b00, 2'b11};
    localparam int          V_ADDR [NV] = '{3, 3, 3, 3, 3, 3, 3, 7, 7, 7, 7, 7};
    localparam logic [31:0] V_WD   [NV] = '{32'hA5A5_0000, 0, 0, 0, 0, 32'hA5A5_0000,
                                           0, 32'h1234_5678, 0, 0, 0, 0};
    localparam logic [31:0] V_EXP  [NV] = '{32'h0, 32'hA5A5_0000, 32'hA5A5_0000,
                                           32'hA5A5_0001, 32'hA5A5_0001, 32'hA5A5_0001,
                                           32'hA5A5_0000, 32'h0, 32'h1234_5678,
                                           32'h1234_5678, 32'h1234_5679, 32'h1234_5679};
    localparam string       V_TAG  [NV] = '{"R5", "R4", "R6", "R6", "R6", "R8",
                                           "R8", "R5", "R4", "R6", "R6", "R11"};

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic single(input int core, input logic [1:0] op, input int addr,
                          input logic [31:0] wd, input logic [31:0] exp, input string tag);
        int waited = 0;
        bit other = 1'b0;
        logic [31:0] got;
        @(negedge clk);
        req_op[core*2 +: 2]     = op;
        req_addr[core*AW +: AW] = AW'(addr);
        req_wdata[core*DW +: DW] = wd;
        req_valid[core]         = 1'b1;
        while (!resp_valid[core] && waited < 60) begin
            @(negedge clk);
            waited++;
            if ((resp_valid & ~(NCORE'(1) << core)) != '0) other = 1'b1;
        end
        got = resp_rdata[core*DW +: DW];
        req_valid[core] = 1'b0;
        check(got == exp, tag, got, exp);
        check(waited <= NCORE*SLOT + SLOT, "R2 latency", 32'(waited), 32'(NCORE*SLOT + SLOT));
        check(!other, "R3 idle slot given away", 32'(other), 0);
        @(negedge clk);
        check(resp_valid == '0, "R9 single pulse", 32'(resp_valid), 0);
    endtask

    initial begin
        int t_first, t_last, nzero, nresp, cyc;
        repeat (3) @(negedge clk);
        check(resp_valid == '0, "R10 reset resp", 32'(resp_valid), 0);
        rst_n = 1'b1;
        // R10: memory clear after reset
        single(2, 2'b00, 20, 0, 32'h0, "R10 mem zero");
        // Table walk
        for (int v = 0; v < NV; v++)
            single(V_CORE[v], V_OP[v], V_ADDR[v], V_WD[v], V_EXP[v], V_TAG[v]);
        // R11: reserved code left word 7 untouched
        single(0, 2'b00, 7, 0, 32'h1234_5679, "R11 no write");
        // R7: four concurrent swaps on free lock word 10
        @(negedge clk);
        for (int c = 0; c < NCORE; c++) begin
            req_op[c*2 +: 2]     = 2'b10;
            req_addr[c*AW +: AW] = AW'(10);
            req_wdata[c*DW +: DW] = '0;
        end
        req_valid = '1;
        t_first = -1; t_last = -1; nzero = 0; nresp = 0; cyc = 0;
        while (nresp < NCORE && cyc < 80) begin
            @(negedge clk);
            cyc++;
            check($countones(resp_valid) <= 1, "R9 onehot", 32'(resp_valid), 1);
            for (int c = 0; c < NCORE; c++) begin
                if (resp_valid[c]) begin
                    nresp++;
                    if (resp_rdata[c*DW] == 1'b0) nzero++;
                    if (t_first < 0) t_first = cyc;
                    t_last = cyc;
                    req_valid[c] = 1'b0;
                end
            end
        end
        check(nresp == NCORE, "R7 all answered", 32'(nresp), NCORE);
        check(nzero == 1, "R7 single winner", 32'(nzero), 1);
        check(t_last - t_first == 3*SLOT, "R7 R1 span", 32'(t_last - t_first), 3*SLOT);
        single(1, 2'b00, 10, 0, 32'h1, "R6 lock left set");
        // R8: release then reacquire
        single(3, 2'b01, 10, 32'h0, 32'h1, "R8 release");
        single(0, 2'b10, 10, 0, 32'h0, "R8 reacquire");
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule